// File: doc/BRIEF.md
# Slave-Port Arbiter with Idle Parking

This block decides which of several bus masters owns a single slave port of a multi-master interconnect. Each master raises a level request. The arbiter returns a one-hot grant and keeps it until the slave side signals the end of the access. When several masters compete, the grant rotates in round-robin order, starting after the master that was granted most recently.

When an access ends and nothing is pending, the port "parks". A 2-bit mode input selects where it parks. It can release every master, stay with the master that used it last, or connect to one master chosen by a 4-bit index. A parked master that raises its request finds its grant already asserted, so its access starts in the same cycle. Any other master waits one cycle while the arbiter switches the grant. When a request is already waiting at the end of an access, the next grant follows in the very next cycle, so back-to-back traffic loses no cycle to arbitration.

Top module: `slave_park_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant vector is all zeros.
- R2: At most one grant bit is high in any cycle.
- R3: Once an access is in progress, the grant stays unchanged until the cycle in which `acc_end` is high. An access is in progress when the port is busy, or when a master requests while its grant is already high.
- R4: With `park_mode` 0 (release), and with the reserved value 3, which acts the same way, an idle port with no request has an all-zero grant from the next cycle. A request then gets its grant one cycle after it is first seen.
- R5: A request that reaches a released, idle port is granted in the cycle after it is first sampled, and not in the same cycle.
- R6: With `park_mode` 1 (stay with last), an access that ends with nothing pending leaves the grant on the master that just finished. That master's next request starts with no wait, and any other master is granted one cycle after its request.
- R7: With `park_mode` 2 (fixed), an idle port grants master `park_sel` from the next cycle. That master starts with no wait, and any other master waits one cycle.
- R8: In fixed mode, a `park_sel` value at or above the number of masters acts as release mode.
- R9: Among simultaneous requesters, the grant goes to the first requesting index after the most recently granted master, wrapping from the top index to 0. Before any access, the last granted master is taken as index 0.
- R10: If any request is high in the cycle an access ends, one of those requesters is granted in the next cycle, with no idle cycle in between.
- R11: In fixed mode, traffic from other masters never moves the fixed park target. After another master's access ends with nothing pending, the grant returns to `park_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_M | Level request, one bit per master |
| acc_end | input | 1 | High in the last cycle of the current access |
| park_mode | input | 2 | 0 release, 1 stay with last, 2 fixed, 3 reserved (release) |
| park_sel | input | 4 | Fixed park target index |
| gnt | output | NUM_M | One-hot grant, all zero when released |

## Verification
The grant is a single register, so every decision made from the inputs at one rising edge shows up on `gnt` after that edge. A request to a released port or to an unparked master is therefore due one edge later, while a parked master's request sees its grant in the same cycle. Inputs change and outputs are sampled on the falling edge. A check on a newly granted requester is placed one falling edge after the request is driven, and a zero-latency check is placed on the edge where the request is driven. A cycle-level reference sweep over every mode and every park index reuses the same timing, comparing the grant at each falling edge against the value predicted from the previous edge's inputs.

// File: rtl/slave_park_arb.sv
module slave_park_arb #(
  parameter int NUM_M = 4,
  localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] req,
  input  logic             acc_end,
  input  logic [1:0]       park_mode,
  input  logic [3:0]       park_sel,
  output logic [NUM_M-1:0] gnt
);

  logic          busy, hist, any_win, in_access;
  logic [IW-1:0] last, gidx, ptr, win;
  logic [NUM_M-1:0] park_vec, gnt_d;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NUM_M; i++)
      if (gnt[i]) gidx = IW'(i);
  end

  assign in_access = busy | (|(req & gnt));
  assign ptr       = in_access ? gidx : last;

  always_comb begin
    int c;
    win = '0;
    any_win = 1'b0;
    for (int k = 1; k <= NUM_M; k++) begin
      c = (int'(ptr) + k) % NUM_M;
      if (!any_win && req[c]) begin
        any_win = 1'b1;
        win = IW'(c);
      end
    end
  end

  always_comb begin
    case (park_mode)
      2'd1:    park_vec = (in_access | hist) ? (NUM_M'(1) << ptr) : '0;
      2'd2:    park_vec = (int'(park_sel) < NUM_M) ? (NUM_M'(1) << park_sel[IW-1:0]) : '0;
      default: park_vec = '0;
    endcase
  end

  always_comb begin
    if (in_access && !acc_end) gnt_d = gnt;
    else if (any_win)          gnt_d = NUM_M'(1) << win;
    else                       gnt_d = park_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt  <= '0;
      busy <= 1'b0;
      last <= '0;
      hist <= 1'b0;
    end else begin
      gnt  <= gnt_d;
      busy <= (in_access && !acc_end) ? 1'b1 : any_win;
      if (in_access) begin
        last <= gidx;
        hist <= 1'b1;
      end
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_access && !acc_end |=> $stable(gnt));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_access && !(|req) && (park_mode == 2'd0 || park_mode == 2'd3) |=> gnt == '0);

  p_stay_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_access && acc_end && !(|req) && park_mode == 2'd1 |=> $stable(gnt));

  p_fixed_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_access && !(|req) && park_mode == 2'd2 && int'(park_sel) < NUM_M
    |=> gnt == (NUM_M'(1) << $past(park_sel)));

  p_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_access && !(|req) && park_mode == 2'd2 && int'(park_sel) >= NUM_M |=> gnt == '0);

  p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_access && acc_end && (|req) |=> (|(gnt & $past(req))));

endmodule

// File: tb/tb_slave_park_arb.sv
module tb_slave_park_arb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         acc_end = 1'b0;
  logic [1:0]   park_mode = 2'd0;
  logic [3:0]   park_sel = 4'd0;
  logic [N-1:0] gnt;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int     m_busy, m_last, m_hist;
  logic [N-1:0] m_gnt;

  slave_park_arb #(.NUM_M(N)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .acc_end(acc_end),
    .park_mode(park_mode), .park_sel(park_sel), .gnt(gnt)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; acc_end = 1'b0;
    repeat (3) tick();
    chk("R1", gnt, '0);
    rst_n = 1'b1;
    tick();
    chk("R1", gnt, '0);
    m_gnt = '0; m_busy = 0; m_last = 0; m_hist = 0;
  endtask

  task automatic model_step();
    int acc, gi, p, w, c;
    logic [N-1:0] ng;
    int nb;
    acc = (m_busy != 0 || (req & m_gnt) != 0) ? 1 : 0;
    gi = 0;
    for (int i = 0; i < N; i++) if (m_gnt[i]) gi = i;
    p = acc ? gi : m_last;
    w = -1;
    for (int k = 1; k <= N; k++) begin
      c = (p + k) % N;
      if (w < 0 && req[c]) w = c;
    end
    if (acc && !acc_end) begin ng = m_gnt; nb = 1; end
    else if (w >= 0) begin ng = N'(1) << w; nb = 1; end
    else begin
      nb = 0;
      if (park_mode == 2'd1 && (acc || m_hist)) ng = N'(1) << p;
      else if (park_mode == 2'd2 && park_sel < N) ng = N'(1) << park_sel;
      else ng = '0;
    end
    if (acc) begin m_last = gi; m_hist = 1; end
    m_gnt = ng; m_busy = nb;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick();
    do_reset();

    // R5/R4: release mode, one-cycle latency, then release to zero
    req = 4'b0010;
    chk("R5", gnt, 4'b0000);
    tick(); chk("R5", gnt, 4'b0010);
    req = '0; acc_end = 1'b1;
    tick(); chk("R4", gnt, 4'b0000);
    acc_end = 1'b0;

    // R6: stay with last master (1)
    park_mode = 2'd1;
    tick(); chk("R6", gnt, 4'b0010);
    req = 4'b0010;
    chk("R6", gnt, 4'b0010);
    tick(); req = '0; acc_end = 1'b1;
    tick(); chk("R6", gnt, 4'b0010);
    acc_end = 1'b0; req = 4'b0100;
    chk("R6", gnt, 4'b0010);
    tick(); chk("R6", gnt, 4'b0100);
    req = '0; acc_end = 1'b1;
    tick(); chk("R6", gnt, 4'b0100);
    acc_end = 1'b0;

    // R7/R11: fixed park target 3
    park_mode = 2'd2; park_sel = 4'd3;
    tick(); chk("R7", gnt, 4'b1000);
    req = 4'b0001;
    tick(); chk("R7", gnt, 4'b0001);
    req = '0; acc_end = 1'b1;
    tick(); chk("R11", gnt, 4'b1000);
    acc_end = 1'b0; req = 4'b1000;
    chk("R7", gnt, 4'b1000);
    tick(); chk("R3", gnt, 4'b1000);
    req = '0; acc_end = 1'b1;
    tick(); chk("R11", gnt, 4'b1000);
    acc_end = 1'b0;

    // R8: out-of-range index, then reserved mode
    park_sel = 4'd9;
    tick(); chk("R8", gnt, 4'b0000);
    park_sel = 4'd3; park_mode = 2'd3;
    tick(); chk("R4", gnt, 4'b0000);

    // R9/R10: all request, last granted was 3
    park_mode = 2'd0; req = 4'b1111;
    tick(); chk("R9", gnt, 4'b0001);
    acc_end = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      tick(); chk("R10", gnt, N'(1) << (k % N));
    end
    acc_end = 1'b0; req = '0;
    tick();

    // Sweep every mode and index against the reference model
    do_reset();
    for (int md = 0; md < 4; md++) begin
      for (int fx = 0; fx < 16; fx++) begin
        park_mode = 2'(md); park_sel = 4'(fx);
        for (int cy = 0; cy < 24; cy++) begin
          string tag;
          if (m_busy != 0) tag = "R3";
          else if (md == 1) tag = "R6";
          else if (md == 2 && fx < N) tag = "R7";
          else if (md == 2) tag = "R8";
          else tag = "R4";
          if ($countones(gnt) > 1) chk("R2", gnt, '0);
          for (int b = 0; b < N; b++) req[b] = ($urandom_range(0, 2) == 0);
          acc_end = $urandom_range(0, 1) == 1;
          model_step();
          tick();
          chk(tag, gnt, m_gnt);
        end
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule